// File: doc/BRIEF.md
# Byte-Programmed Single-Channel PWM Generator

This block drives one pulse-width-modulated output whose period and high time are 16-bit counts of a fixed tick. A host programs it through a write-only port that carries an 8-bit address and an 8-bit data byte per strobe. Every 16-bit setting is sent as two bytes. The upper byte is only held in a staging register. The full value takes effect in the same cycle as the write of its lower byte. As a result, between the two commits, the period and the high time can briefly belong to different settings. The design handles that window by defining a fully-on output whenever the high time reaches the period.

The tick is taken from the system clock through a parameterised divider. Set `TICK_DIV` so that one tick lasts 125 ns, which is 8 at a 64 MHz clock. An auto-off countdown can stop the output after a programmed number of whole periods. Loading it with all ones turns that feature off, and all ones is its value after reset.

The write port is a plain strobe and has no back-pressure. Each cycle with `wr_en` high is taken in that cycle, and the host may issue a write on every clock.

Top module: `pwmb_top`

## Requirements
- R1: Address decode uses the 8-bit `wr_addr` and acts only when `wr_en` is high. Duty low is 0xA6 and duty high is 0xA7. Period low is 0xA4 and period high is 0xA5. 0xA3 is the enable register, 0xA2 is the auto-off low byte and 0xA1 is the auto-off high byte. A write to any other address changes nothing. There is no readback.
- R2: A high-byte write only stages its byte and leaves the active value unchanged. A low-byte write makes {staged high, written low} the active value in that cycle, and the output reflects the new value from the next cycle on.
- R3: One tick occurs every `TICK_DIV` clocks. While enabled, the position counter advances on each tick and wraps to 0 once it has reached period−1. With period P ≥ 1, the output therefore repeats every P·`TICK_DIV` clocks.
- R4: The output has normal polarity. For a non-zero duty D below the period, it is high while the position counter is below D and low for the rest of the period.
- R5: With a non-zero duty that is greater than or equal to the period, the output stays high continuously. This includes a period of 0.
- R6: With a duty of 0, the output stays low even when enabled.
- R7: Only bit 0 of the enable register counts: 1 runs the output and 0 stops it. When stopped, the output is low and the counter is cleared, so a restart begins a fresh period that is high in its first cycle.
- R8: The auto-off value is 0xFFFF after reset, and its staged high byte resets to 0xFF. While the value is 0xFFFF it never changes on its own, and the output runs indefinitely.
- R9: Any other non-zero auto-off value drops by one at the end of each completed period while enabled. When it reaches 0, enable is cleared. While it is 0, enable cannot be set.
- R10: Reset clears enable, the active period and duty, their staged high bytes and the counter, and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register write per high cycle |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Byte written |
| pwm_o | output | 1 | PWM output |

## Verification
The duty cycle is measured as the count of high cycles in any window of one full period. The bench uses a duty below the period, a duty equal to it, a duty far above it, a duty of zero and a period of zero. These cases separate the compare-based waveform from the fully-on and fully-off cases. A staged upper byte followed by its lower byte shows whether a commit is tied to the low write alone. A short auto-off count followed by an all-ones load separates the countdown from the disable value. Seeded random byte writes, including stray addresses, are compared every cycle against a bench model built from the requirements.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;
  localparam int BYTE_W  = 8;
  localparam int VAL_W   = 2 * BYTE_W;
  localparam int N_SLOTS = 3;
  localparam int SLOT_AUTO = 0;
  localparam int SLOT_PER  = 1;
  localparam int SLOT_DUTY = 2;

  typedef enum logic [BYTE_W-1:0] {
    ADR_AUTO_HI = 8'hA1,
    ADR_AUTO_LO = 8'hA2,
    ADR_ENABLE  = 8'hA3,
    ADR_PER_LO  = 8'hA4,
    ADR_PER_HI  = 8'hA5,
    ADR_DUTY_LO = 8'hA6,
    ADR_DUTY_HI = 8'hA7
  } pwmb_addr_e;

  function automatic logic [BYTE_W-1:0] slot_hi(input int s);
    case (s)
      SLOT_AUTO: return ADR_AUTO_HI;
      SLOT_PER:  return ADR_PER_HI;
      default:   return ADR_DUTY_HI;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] slot_lo(input int s);
    case (s)
      SLOT_AUTO: return ADR_AUTO_LO;
      SLOT_PER:  return ADR_PER_LO;
      default:   return ADR_DUTY_LO;
    endcase
  endfunction

  // staged upper byte after reset: auto-off keeps all ones
  function automatic logic [BYTE_W-1:0] slot_hi_rst(input int s);
    return (s == SLOT_AUTO) ? '1 : '0;
  endfunction
endpackage

// File: rtl/pwmb_tick.sv
module pwmb_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] pre_q;

      assign tick_o = (pre_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
      end

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R3
    end
  endgenerate
endmodule

// File: rtl/pwmb_pair.sv
module pwmb_pair #(
  parameter int BYTE_W = pwmb_pkg::BYTE_W,
  parameter logic [BYTE_W-1:0] HI_ADDR = '0,
  parameter logic [BYTE_W-1:0] LO_ADDR = '0,
  parameter logic [BYTE_W-1:0] HI_RST  = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [BYTE_W-1:0]     wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic                  load_o,
  output logic [2*BYTE_W-1:0]   value_o
);
  logic [BYTE_W-1:0] hi_q;

  // upper byte is only staged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             hi_q <= HI_RST;
    else if (wr_en && wr_addr == HI_ADDR)   hi_q <= wr_data;
  end

  // lower byte write commits the full word
  assign load_o  = wr_en && (wr_addr == LO_ADDR);
  assign value_o = {hi_q, wr_data};
endmodule

// File: rtl/pwmb_regs.sv
module pwmb_regs
  import pwmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              period_end,
  output logic              en_o,
  output logic [VAL_W-1:0]  period_o,
  output logic [VAL_W-1:0]  duty_o
);
  localparam logic [VAL_W-1:0] ALL_ONES = '1;

  logic [N_SLOTS-1:0] load;
  logic [VAL_W-1:0]   val [N_SLOTS];

  generate
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      pwmb_pair #(
        .BYTE_W (BYTE_W),
        .HI_ADDR(slot_hi(s)),
        .LO_ADDR(slot_lo(s)),
        .HI_RST (slot_hi_rst(s))
      ) u_pair (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .load_o (load[s]),
        .value_o(val[s])
      );
    end
  endgenerate

  logic             en_q, en_d;
  logic [VAL_W-1:0] per_q, duty_q, auto_q, auto_d;
  logic             en_wr;
  logic [BYTE_W-2:0] unused_en_bits;

  assign en_wr          = wr_en && (wr_addr == ADR_ENABLE);
  assign unused_en_bits = wr_data[BYTE_W-1:1];

  always_comb begin
    auto_d = auto_q;
    if (load[SLOT_AUTO])
      auto_d = val[SLOT_AUTO];
    else if (period_end && en_q && auto_q != ALL_ONES && auto_q != '0)
      auto_d = auto_q - 1'b1;

    en_d = en_q;
    if (en_wr)
      en_d = wr_data[0];
    if (auto_d == '0)
      en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
      auto_q <= ALL_ONES;
    end else begin
      en_q   <= en_d;
      auto_q <= auto_d;
      if (load[SLOT_PER])  per_q  <= val[SLOT_PER];
      if (load[SLOT_DUTY]) duty_q <= val[SLOT_DUTY];
    end
  end

  assign en_o     = en_q;
  assign period_o = per_q;
  assign duty_o   = duty_q;

  AST_AUTO_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q == '0) |-> !en_q); // R9
  AST_AUTO_ONES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q == ALL_ONES && !(wr_en && wr_addr == ADR_AUTO_LO)) |=> (auto_q == ALL_ONES)); // R8
  AST_PER_HI_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_PER_HI) |=> $stable(per_q)); // R2
  AST_DUTY_HI_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_DUTY_HI) |=> $stable(duty_q)); // R2
  AST_STRAY_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(wr_addr inside {[8'hA1:8'hA7]}) && !period_end) |=>
      ($stable(per_q) && $stable(duty_q) && $stable(auto_q))); // R1
endmodule

// File: rtl/pwmb_core.sv
module pwmb_core #(
  parameter int VAL_W = pwmb_pkg::VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [VAL_W-1:0] period,
  input  logic [VAL_W-1:0] duty,
  output logic             pwm_o,
  output logic             period_end_o
);
  logic [VAL_W-1:0] cnt_q;
  logic             at_last;

  // a shrunk period may leave the counter past its end: wrap at once
  assign at_last      = (period == '0) || (cnt_q >= period - 1'b1);
  assign period_end_o = en && tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en)     cnt_q <= '0;
    else if (tick)    cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  assign pwm_o = en && (duty != '0) && ((duty >= period) || (cnt_q < duty));

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R7
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/pwmb_top.sv
module pwmb_top
  import pwmb_pkg::*;
#(
  parameter int TICK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              pwm_o
);
  logic             tick, en, pend;
  logic [VAL_W-1:0] period, duty;

  pwmb_tick #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(tick)
  );

  pwmb_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .period_end(pend),
    .en_o      (en),
    .period_o  (period),
    .duty_o    (duty)
  );

  pwmb_core #(.VAL_W(VAL_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .en          (en),
    .period      (period),
    .duty        (duty),
    .pwm_o       (pwm_o),
    .period_end_o(pend)
  );

  AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en && duty != '0 && duty >= period) |-> pwm_o); // R5
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !pwm_o); // R6
  AST_END_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (tick && en)); // R3
endmodule

// File: tb/pwmb_top_tb.sv
module pwmb_top_tb;
  localparam int TDIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       pwm_o;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwmb_top #(.TICK_DIV(TDIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
  );

  // reference model built from the requirements
  int          m_pre;
  logic        m_en;
  logic [15:0] m_per, m_duty, m_auto, m_cnt;
  logic [7:0]  m_phi, m_dhi, m_ahi;
  logic        m_out;

  assign m_out = m_en && (m_duty != 0) && ((m_duty >= m_per) || (m_cnt < m_duty));

  always @(posedge clk or negedge rst_n) begin
    logic tk, last, pend, e_n;
    logic [15:0] a_n;
    if (!rst_n) begin
      m_pre <= 0; m_en <= 1'b0; m_per <= 0; m_duty <= 0; m_cnt <= 0;
      m_phi <= 0; m_dhi <= 0; m_ahi <= 8'hFF; m_auto <= 16'hFFFF;
    end else begin
      tk   = (m_pre == TDIV - 1);
      last = (m_per == 0) || (m_cnt >= m_per - 16'd1);
      pend = m_en && tk && last;
      m_pre <= tk ? 0 : m_pre + 1;
      m_cnt <= !m_en ? 16'd0 : (tk ? (last ? 16'd0 : m_cnt + 16'd1) : m_cnt);
      a_n = m_auto;
      e_n = m_en;
      if (pend && m_auto != 16'hFFFF && m_auto != 0) a_n = m_auto - 16'd1;
      if (wr_en) begin
        case (wr_addr)
          8'hA1: m_ahi <= wr_data;
          8'hA2: a_n = {m_ahi, wr_data};
          8'hA3: e_n = wr_data[0];
          8'hA4: m_per <= {m_phi, wr_data};
          8'hA5: m_phi <= wr_data;
          8'hA6: m_duty <= {m_dhi, wr_data};
          8'hA7: m_dhi <= wr_data;
          default: ;
        endcase
      end
      if (a_n == 0) e_n = 1'b0;
      m_auto <= a_n;
      m_en   <= e_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison (R4 waveform)
  always @(negedge clk) begin
    if (cmp_on) chk(pwm_o === m_out, "R4 model compare", int'(pwm_o), int'(m_out));
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_o) c++;
      @(negedge clk);
    end
  endtask

  task automatic rise_gap(output int g);
    int guard;
    g = 0; guard = 0;
    while (pwm_o && guard < 2000) begin @(negedge clk); guard++; end
    while (!pwm_o && guard < 2000) begin @(negedge clk); guard++; end
    while (pwm_o && guard < 2000) begin @(negedge clk); g++; guard++; end
    while (!pwm_o && guard < 2000) begin @(negedge clk); g++; guard++; end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    int g;
    logic [7:0] a, d;
    void'($urandom(32'd20240917));
    idle(5);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    chk(pwm_o == 1'b0, "R10 reset output low", int'(pwm_o), 0);

    // enabled with reset values: period 0, duty 0
    wr(8'hA3, 8'h01);
    idle(20);
    count_high(80, c); chk(c == 0, "R10 R6 reset values give low output", c, 0);

    // period 10 ticks, duty 3 ticks
    wr(8'hA5, 8'h00); wr(8'hA4, 8'd10);
    wr(8'hA7, 8'h00); wr(8'hA6, 8'd3);
    idle(200);
    count_high(80, c); chk(c == 24, "R4 duty 3 of 10", c, 24);
    rise_gap(g); chk(g == 80, "R3 repeat interval", g, 80);

    // staging of the duty upper byte
    wr(8'hA7, 8'h01);
    idle(200);
    count_high(80, c); chk(c == 24, "R2 staged byte inactive", c, 24);
    wr(8'hA6, 8'h00);
    idle(100);
    count_high(80, c); chk(c == 80, "R2 R5 commit on low byte, duty above period", c, 80);

    // duty equal to period
    wr(8'hA7, 8'h00); wr(8'hA6, 8'd10);
    idle(100);
    count_high(80, c); chk(c == 80, "R5 duty equals period", c, 80);

    // zero duty while enabled
    wr(8'hA6, 8'd0);
    idle(100);
    count_high(80, c); chk(c == 0, "R6 zero duty low", c, 0);

    // period 0 with non-zero duty
    wr(8'hA6, 8'd3); wr(8'hA4, 8'd0);
    idle(100);
    count_high(80, c); chk(c == 80, "R5 zero period high", c, 80);
    wr(8'hA4, 8'd10);
    idle(200);

    // stray addresses
    wr(8'hA8, 8'h55); wr(8'hA0, 8'h00); wr(8'h10, 8'h00);
    idle(100);
    count_high(80, c); chk(c == 24, "R1 stray writes ignored", c, 24);

    // enable bit 0 only
    wr(8'hA3, 8'hFE);
    idle(20);
    count_high(80, c); chk(c == 0, "R7 disabled output low", c, 0);
    wr(8'hA3, 8'h01);
    chk(pwm_o == 1'b1, "R7 restart high in first cycle", int'(pwm_o), 1);
    idle(100);
    count_high(80, c); chk(c == 24, "R7 running after restart", c, 24);

    // auto-off after two periods
    wr(8'hA3, 8'h00); wr(8'hA1, 8'h00); wr(8'hA2, 8'h02);
    wr(8'hA3, 8'h01);
    count_high(400, c); chk(c >= 41 && c <= 48, "R9 two periods then stop", c, 48);
    count_high(80, c); chk(c == 0, "R9 stopped", c, 0);
    wr(8'hA3, 8'h01);
    count_high(80, c); chk(c == 0, "R9 enable refused at zero", c, 0);

    // all ones disables the countdown
    wr(8'hA1, 8'hFF); wr(8'hA2, 8'hFF); wr(8'hA3, 8'h01);
    idle(2000);
    count_high(80, c); chk(c == 24, "R8 all ones never stops", c, 24);

    // seeded random byte writes against the model
    for (int k = 0; k < 2500; k++) begin
      case ($urandom % 8)
        0: begin a = 8'hA1; d = ($urandom % 4 == 0) ? 8'h00 : 8'hFF; end
        1: begin a = 8'hA2; d = ($urandom % 3 == 0) ? 8'($urandom % 6) : 8'hFF; end
        2: begin a = 8'hA3; d = ($urandom % 4 != 0) ? 8'h01 : 8'h00; end
        3: begin a = 8'hA4; d = 8'($urandom % 24); end
        4: begin a = 8'hA5; d = ($urandom % 10 == 0) ? 8'h01 : 8'h00; end
        5: begin a = 8'hA6; d = 8'($urandom % 30); end
        6: begin a = 8'hA7; d = ($urandom % 10 == 0) ? 8'h01 : 8'h00; end
        default: begin a = 8'($urandom); d = 8'($urandom); end
      endcase
      wr(a, d);
      idle(int'($urandom % 12));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule